// File: doc/BRIEF.md
# ASID-Qualified Hardware Breakpoint Unit

This block watches the instruction fetch stream and the operand access stream of a processor core. It raises a debug trigger when an access matches conditions that software has programmed. Each address comparison works on a 40-bit virtual address, with the 8-bit address space identifier placed above the 32-bit address. A comparator can therefore tell the same address apart in different processes. For each comparator, a control bit decides whether the identifier takes part in the match.

Four instruction-address comparators and one operand address comparator are provided. An operand data comparator with a byte-lane mask completes the set. Each comparator has its own identifier field and its own enable. The hit flags are registered. The first hit after the status bit has been cleared produces a one-cycle trigger. A mode bit routes this trigger either to a halt request or to a debug interrupt request. A sticky status bit records that the trigger fired and holds until software clears it. A constant output reports debug revision level 3.

The core configures the unit through a simple write port that takes a register index and 32 bits of data. Reset is asynchronous and active low. It is released synchronously through a two-stage synchronizer.

Top module: `asid_bkpt_unit`

## Requirements
- R1: When a PC comparator has its identifier-include bit set, it hits only when both the fetch address and `cur_asid` equal its programmed address and identifier.
- R2: When a comparator's identifier-include bit is clear, `cur_asid` has no effect on the match, and only the 32-bit address is compared.
- R3: The four PC comparators are independent. Comparator i drives `pc_hit[i]` only.
- R4: A comparator whose enable bit is clear never hits. Every enable bit is clear after reset.
- R5: The operand address comparator matches on its address and, optionally, its own identifier. Control bit 4 admits reads (`opnd_wr`=0) and control bit 5 admits writes (`opnd_wr`=1).
- R6: The operand data comparator compares only the byte lanes whose mask bit is set. Mask bit k covers data bits 8k+7..8k. The comparator can optionally also require its own identifier.
- R7: Neither operand comparator hits unless `opnd_vld` is high.
- R8: A hit flag rises in the cycle after the matching access and lasts one cycle.
- R9: `halt_req`/`dbg_irq` pulse for one cycle on a hit only while `trig_sticky` is clear. `trig_sticky` then stays set until a write to index 15 with bit 1 set clears it.
- R10: The action bit (index 15 bit 0) routes the trigger pulse. A value of 0 selects `halt_req` and a value of 1 selects `dbg_irq`.
- R11: `rev_level` reads 3.
- R12: The register map is as follows.
  - Indices 0-3 hold the PC addresses and indices 4-7 hold the PC identifiers (bits 7:0).
  - Index 8 holds the operand address and index 9 holds its identifier.
  - Index 10 holds the data value, index 11 holds the data identifier and index 12 holds the lane mask.
  - Index 13 is the PC control register. Bit i enables comparator i and bit 8+i is its include bit.
  - Index 14 is the operand control register. Bit 0 enables the address comparator and bit 1 is its include bit. Bit 2 enables the data comparator and bit 3 is its include bit. Bits 4 and 5 are the read and write qualifiers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Register index |
| wr_data | input | 32 | Register write data |
| fetch_vld | input | 1 | Instruction fetch valid |
| fetch_pc | input | 32 | Fetch address |
| cur_asid | input | 8 | Current address space identifier |
| opnd_vld | input | 1 | Operand access valid |
| opnd_wr | input | 1 | Operand access is a write |
| opnd_addr | input | 32 | Operand address |
| opnd_data | input | 32 | Operand data |
| pc_hit | output | 4 | Registered PC comparator hits |
| op_addr_hit | output | 1 | Registered operand address hit |
| op_data_hit | output | 1 | Registered operand data hit |
| halt_req | output | 1 | One-cycle halt request |
| dbg_irq | output | 1 | One-cycle debug interrupt request |
| trig_sticky | output | 1 | Trigger status, set until cleared |
| rev_level | output | 4 | Debug revision level (3) |

## Verification
The bench builds the unit with its default parameters: four PC comparators, 32-bit addresses and data, and 8-bit identifiers. With these values the 16-entry map fits a 4-bit index exactly. All four comparators can be set to one address with different identifiers to show that they are independent. Four byte lanes allow partial-mask data matches to be tried against mismatches in masked-out lanes. The trigger path is driven in both action modes, and the sticky bit is exercised through set, repeated hits and clear.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int REV_LEVEL = 3;

  // operand control layout, LSB first: a_en, a_asid, d_en, d_asid, rd, wr
  typedef struct packed {
    logic wr;
    logic rd;
    logic d_asid;
    logic d_en;
    logic a_asid;
    logic a_en;
  } opctl_t;
endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
  import bkpt_pkg::*;
#(
  parameter int NUM_PC = 4,
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int ASW    = 8,
  parameter int IW     = 4,
  localparam int LANES = DW / 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [IW-1:0]                 wr_idx,
  input  logic [31:0]                   wr_data,
  output logic [NUM_PC-1:0][AW-1:0]     pc_addr,
  output logic [NUM_PC-1:0][ASW-1:0]    pc_asid,
  output logic [NUM_PC-1:0]             pc_en,
  output logic [NUM_PC-1:0]             pc_asid_inc,
  output logic [AW-1:0]                 op_addr,
  output logic [ASW-1:0]                op_asid,
  output logic [DW-1:0]                 d_val,
  output logic [ASW-1:0]                d_asid,
  output logic [LANES-1:0]              d_mask,
  output opctl_t                        opctl,
  output logic                          act_irq,
  output logic                          sticky_clr
);
  localparam int IX_OADDR = 2 * NUM_PC;
  localparam int IX_OASID = IX_OADDR + 1;
  localparam int IX_DVAL  = IX_OADDR + 2;
  localparam int IX_DASID = IX_OADDR + 3;
  localparam int IX_DMASK = IX_OADDR + 4;
  localparam int IX_PCCTL = IX_OADDR + 5;
  localparam int IX_OPCTL = IX_OADDR + 6;
  localparam int IX_TRIG  = IX_OADDR + 7;
  localparam int NREG     = IX_TRIG + 1;
  localparam int INC_OFS  = 8;

  logic [NREG-1:0] sel;

  always_comb begin
    for (int k = 0; k < NREG; k++) sel[k] = wr_en && (wr_idx == IW'(k));
    sticky_clr = sel[IX_TRIG] && wr_data[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_addr     <= '0;
      pc_asid     <= '0;
      pc_en       <= '0;
      pc_asid_inc <= '0;
      op_addr     <= '0;
      op_asid     <= '0;
      d_val       <= '0;
      d_asid      <= '0;
      d_mask      <= '0;
      opctl       <= '0;
      act_irq     <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_PC; i++) begin
        if (sel[i])          pc_addr[i] <= wr_data[AW-1:0];
        if (sel[NUM_PC + i]) pc_asid[i] <= wr_data[ASW-1:0];
      end
      if (sel[IX_OADDR]) op_addr <= wr_data[AW-1:0];
      if (sel[IX_OASID]) op_asid <= wr_data[ASW-1:0];
      if (sel[IX_DVAL])  d_val   <= wr_data[DW-1:0];
      if (sel[IX_DASID]) d_asid  <= wr_data[ASW-1:0];
      if (sel[IX_DMASK]) d_mask  <= wr_data[LANES-1:0];
      if (sel[IX_PCCTL]) begin
        pc_en       <= wr_data[NUM_PC-1:0];
        pc_asid_inc <= wr_data[INC_OFS +: NUM_PC];
      end
      if (sel[IX_OPCTL]) opctl   <= opctl_t'(wr_data[5:0]);
      if (sel[IX_TRIG])  act_irq <= wr_data[0];
    end
  end

  a_r4_ctl_written_only: assert property (@(posedge clk) disable iff (!rst_n)
    !sel[IX_PCCTL] |=> $stable(pc_en));
endmodule

// File: rtl/bkpt_addr_cmp.sv
module bkpt_addr_cmp #(
  parameter int AW  = 32,
  parameter int ASW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           asid_inc,
  input  logic [AW-1:0]  ref_addr,
  input  logic [ASW-1:0] ref_asid,
  input  logic           vld,
  input  logic [AW-1:0]  addr,
  input  logic [ASW-1:0] asid,
  output logic           hit_q
);
  localparam int VAW = ASW + AW;

  logic [VAW-1:0] va_cur, va_ref;
  logic           match_d;

  always_comb begin
    va_cur  = {asid, addr};
    va_ref  = {(asid_inc ? ref_asid : asid), ref_addr};
    match_d = vld && en && (va_cur == va_ref);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= match_d;
  end

  a_r4_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !hit_q);
  a_r8_hit_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> !hit_q);
endmodule

// File: rtl/bkpt_data_cmp.sv
module bkpt_data_cmp #(
  parameter int DW  = 32,
  parameter int ASW = 8,
  localparam int LANES = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             asid_inc,
  input  logic [DW-1:0]    ref_data,
  input  logic [ASW-1:0]   ref_asid,
  input  logic [LANES-1:0] mask,
  input  logic             vld,
  input  logic [DW-1:0]    data,
  input  logic [ASW-1:0]   asid,
  output logic             hit_q
);
  logic [DW-1:0] lane_bits;
  logic          match_d;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_bits[8*k +: 8] = {8{mask[k]}};
  end

  always_comb begin
    match_d = vld && en && (((data ^ ref_data) & lane_bits) == '0)
              && (!asid_inc || (asid == ref_asid));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= match_d;
  end

  a_r7_data_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> !hit_q);
endmodule

// File: rtl/bkpt_trig.sv
module bkpt_trig #(
  parameter int NHIT = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NHIT-1:0] hits,
  input  logic            act_irq,
  input  logic            sticky_clr,
  output logic            halt_req,
  output logic            dbg_irq,
  output logic            sticky
);
  logic any_hit, fire, sticky_d;

  always_comb begin
    any_hit  = |hits;
    fire     = any_hit && !sticky;
    halt_req = fire && !act_irq;
    dbg_irq  = fire && act_irq;
    if (any_hit)         sticky_d = 1'b1;
    else if (sticky_clr) sticky_d = 1'b0;
    else                 sticky_d = sticky;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky <= 1'b0;
    else        sticky <= sticky_d;
  end

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req || dbg_irq) |=> !(halt_req || dbg_irq));
  a_r9_sticky_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req || dbg_irq) |=> sticky);
  a_r9_sticky_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sticky) |-> $past(any_hit));
endmodule

// File: rtl/asid_bkpt_unit.sv
module asid_bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int NUM_PC = 4,
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int ASW    = 8,
  parameter int IW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [31:0]       wr_data,
  input  logic              fetch_vld,
  input  logic [AW-1:0]     fetch_pc,
  input  logic [ASW-1:0]    cur_asid,
  input  logic              opnd_vld,
  input  logic              opnd_wr,
  input  logic [AW-1:0]     opnd_addr,
  input  logic [DW-1:0]     opnd_data,
  output logic [NUM_PC-1:0] pc_hit,
  output logic              op_addr_hit,
  output logic              op_data_hit,
  output logic              halt_req,
  output logic              dbg_irq,
  output logic              trig_sticky,
  output logic [3:0]        rev_level
);
  localparam int LANES = DW / 8;
  localparam int NHIT  = NUM_PC + 2;

  logic [1:0]                 rst_sync;
  logic                       rst_s;
  logic [NUM_PC-1:0][AW-1:0]  pc_addr;
  logic [NUM_PC-1:0][ASW-1:0] pc_asid;
  logic [NUM_PC-1:0]          pc_en, pc_asid_inc;
  logic [AW-1:0]              op_addr;
  logic [ASW-1:0]             op_asid, d_asid;
  logic [DW-1:0]              d_val;
  logic [LANES-1:0]           d_mask;
  opctl_t                     opctl;
  logic                       act_irq, sticky_clr, op_vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s     = rst_sync[1];
  assign rev_level = 4'(REV_LEVEL);

  always_comb op_vld_q = opnd_vld && (opnd_wr ? opctl.wr : opctl.rd);

  bkpt_regs #(.NUM_PC(NUM_PC), .AW(AW), .DW(DW), .ASW(ASW), .IW(IW)) u_regs (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .pc_addr(pc_addr), .pc_asid(pc_asid), .pc_en(pc_en), .pc_asid_inc(pc_asid_inc),
    .op_addr(op_addr), .op_asid(op_asid), .d_val(d_val), .d_asid(d_asid),
    .d_mask(d_mask), .opctl(opctl), .act_irq(act_irq), .sticky_clr(sticky_clr));

  for (genvar i = 0; i < NUM_PC; i++) begin : g_pc
    bkpt_addr_cmp #(.AW(AW), .ASW(ASW)) u_cmp (
      .clk(clk), .rst_n(rst_s), .en(pc_en[i]), .asid_inc(pc_asid_inc[i]),
      .ref_addr(pc_addr[i]), .ref_asid(pc_asid[i]), .vld(fetch_vld),
      .addr(fetch_pc), .asid(cur_asid), .hit_q(pc_hit[i]));
  end

  bkpt_addr_cmp #(.AW(AW), .ASW(ASW)) u_opa (
    .clk(clk), .rst_n(rst_s), .en(opctl.a_en), .asid_inc(opctl.a_asid),
    .ref_addr(op_addr), .ref_asid(op_asid), .vld(op_vld_q),
    .addr(opnd_addr), .asid(cur_asid), .hit_q(op_addr_hit));

  bkpt_data_cmp #(.DW(DW), .ASW(ASW)) u_opd (
    .clk(clk), .rst_n(rst_s), .en(opctl.d_en), .asid_inc(opctl.d_asid),
    .ref_data(d_val), .ref_asid(d_asid), .mask(d_mask), .vld(op_vld_q),
    .data(opnd_data), .asid(cur_asid), .hit_q(op_data_hit));

  bkpt_trig #(.NHIT(NHIT)) u_trig (
    .clk(clk), .rst_n(rst_s), .hits({op_data_hit, op_addr_hit, pc_hit}),
    .act_irq(act_irq), .sticky_clr(sticky_clr),
    .halt_req(halt_req), .dbg_irq(dbg_irq), .sticky(trig_sticky));

  a_r7_operand_needs_valid: assert property (@(posedge clk) disable iff (!rst_s)
    !opnd_vld |=> !(op_addr_hit || op_data_hit));
  a_r8_pc_hit_after_fetch: assert property (@(posedge clk) disable iff (!rst_s)
    (|pc_hit) |-> $past(fetch_vld));
endmodule

// File: tb/sim_asid_bkpt_unit.sv
module sim_asid_bkpt_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [31:0] wr_data;
  logic        fetch_vld;
  logic [31:0] fetch_pc;
  logic [7:0]  cur_asid;
  logic        opnd_vld, opnd_wr;
  logic [31:0] opnd_addr, opnd_data;
  logic [3:0]  pc_hit;
  logic        op_addr_hit, op_data_hit, halt_req, dbg_irq, trig_sticky;
  logic [3:0]  rev_level;

  int checks = 0;
  int fails  = 0;
  logic [3:0] g_pc;
  logic g_oa, g_od, g_halt, g_irq;

  always #4 clk = ~clk;

  asid_bkpt_unit u0 (.*);

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(int idx, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic capture();
    @(posedge clk); #1;
    g_pc = pc_hit; g_oa = op_addr_hit; g_od = op_data_hit;
    g_halt = halt_req; g_irq = dbg_irq;
    @(negedge clk);
    fetch_vld = 1'b0; opnd_vld = 1'b0;
  endtask

  task automatic fetch(logic [31:0] pc, logic [7:0] asid);
    @(negedge clk);
    fetch_vld = 1'b1; fetch_pc = pc; cur_asid = asid;
    capture();
  endtask

  task automatic opnd(logic w, logic [31:0] a, logic [31:0] d, logic [7:0] asid, logic v);
    @(negedge clk);
    opnd_vld = v; opnd_wr = w; opnd_addr = a; opnd_data = d; cur_asid = asid;
    capture();
  endtask

  task automatic t_reset();
    chk("R11 rev", rev_level, 4'd3);
    chk("R4 reset hits", {pc_hit, op_addr_hit, op_data_hit}, 0);
    chk("R9 reset sticky", trig_sticky, 0);
    fetch(32'h0, 8'h0);
    chk("R4 disabled after reset", g_pc, 0);
  endtask

  task automatic t_pc_asid();
    wr(0, 32'h1000); wr(4, 32'h05);        // R12 indices 0, 4
    wr(13, 32'h0000_0101);                 // R12 enable+include comp0
    fetch(32'h1000, 8'h06);
    chk("R1 asid mismatch", g_pc, 4'b0000);
    fetch(32'h1000, 8'h05);
    chk("R1 40-bit match", g_pc, 4'b0001);
    chk("R10 halt pulse", {g_halt, g_irq}, 2'b10);
    @(posedge clk); #1;
    chk("R8 hit one cycle", pc_hit, 4'b0000);
    chk("R9 sticky set", trig_sticky, 1);
    fetch(32'h1000, 8'h05);
    chk("R9 no second pulse", {g_pc, g_halt, g_irq}, {4'b0001, 2'b00});
    wr(15, 32'h2);
    chk("R9 sticky cleared", trig_sticky, 0);
  endtask

  task automatic t_no_asid();
    wr(1, 32'h2000); wr(5, 32'h33);
    wr(13, 32'h0000_0103);                 // comp1 enabled, include clear
    fetch(32'h2000, 8'h77);
    chk("R2 asid ignored", g_pc, 4'b0010);
    fetch(32'h2004, 8'h33);
    chk("R2 address still compared", g_pc, 4'b0000);
    wr(15, 32'h2);
  endtask

  task automatic t_multi();
    wr(0, 32'h3000); wr(2, 32'h3000); wr(3, 32'h3000);
    wr(6, 32'h0A); wr(7, 32'h0B);
    wr(13, 32'h0000_0C0C);                 // comps 2,3 on with include; comp0 off
    fetch(32'h3000, 8'h0B);
    chk("R3 only comp3", g_pc, 4'b1000);
    fetch(32'h3000, 8'h0A);
    chk("R3 only comp2 (R4 comp0 off)", g_pc, 4'b0100);
    wr(13, 32'h0);
    fetch(32'h3000, 8'h0A);
    chk("R4 all disabled", g_pc, 4'b0000);
    wr(15, 32'h2);
  endtask

  task automatic t_operand();
    wr(8, 32'h4000); wr(9, 32'h09);
    wr(14, 32'h13);                        // addr en+include, reads only
    opnd(1'b0, 32'h4000, 32'h0, 8'h09, 1'b1);
    chk("R5 read match", g_oa, 1);
    opnd(1'b1, 32'h4000, 32'h0, 8'h09, 1'b1);
    chk("R5 write filtered", g_oa, 0);
    opnd(1'b0, 32'h4000, 32'h0, 8'h08, 1'b1);
    chk("R5 operand asid", g_oa, 0);
    opnd(1'b0, 32'h4000, 32'h0, 8'h09, 1'b0);
    chk("R7 no valid", g_oa, 0);
    wr(15, 32'h2);
  endtask

  task automatic t_data();
    wr(10, 32'h1122_3344); wr(11, 32'h02); wr(12, 32'h3);
    wr(14, 32'h34);                        // data en, rd+wr, no include
    opnd(1'b1, 32'h0, 32'hAABB_3344, 8'h00, 1'b1);
    chk("R6 masked lanes ignored", g_od, 1);
    opnd(1'b0, 32'h0, 32'h1122_3345, 8'h00, 1'b1);
    chk("R6 compared lane differs", g_od, 0);
    wr(14, 32'h3C);                        // include data asid
    opnd(1'b0, 32'h0, 32'h1122_3344, 8'h03, 1'b1);
    chk("R6 data asid mismatch", g_od, 0);
    opnd(1'b0, 32'h0, 32'h1122_3344, 8'h02, 1'b1);
    chk("R6 data asid match", g_od, 1);
    opnd(1'b0, 32'h0, 32'h1122_3344, 8'h02, 1'b0);
    chk("R7 data needs valid", g_od, 0);
    wr(15, 32'h2);
  endtask

  task automatic t_irq();
    wr(15, 32'h3);                         // R10 interrupt mode, clear
    wr(13, 32'h0000_0001); wr(0, 32'h5000);
    fetch(32'h5000, 8'hFF);
    chk("R10 irq route", {g_halt, g_irq}, 2'b01);
    @(posedge clk); #1;
    chk("R9 sticky after irq", trig_sticky, 1);
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    fetch_vld = 1'b0; fetch_pc = '0; cur_asid = '0;
    opnd_vld = 1'b0; opnd_wr = 1'b0; opnd_addr = '0; opnd_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_pc_asid();
    t_no_asid();
    t_multi();
    t_operand();
    t_data();
    t_irq();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule